// File: doc/BRIEF.md
# Dual-slope PWM timer channel

This block is an 8-bit timer with a single compare output that generates a centre-aligned PWM waveform. The counter climbs from 0 to 255 and then falls back to 0. It advances only on ticks from a prescaler. The prescaler is a clock enable on the system clock and divides by 1, 8, 32, 64, 128, 256 or 1024, or holds the timer stopped. One full up-down sweep takes 510 ticks, so the PWM frequency is the clock divided by N×510.

The compare value arrives on a plain input, which acts as the buffered copy. The active compare value is taken from that input only when the counter reaches its top value. A write in the middle of a period therefore never cuts a pulse short.

The output level is defined so that the waveform stays symmetric around the bottom of the sweep. At the top it always takes the level that an up-count match would leave, even if no match happened. A compare of 0 or 255 gives a constant level. An invert input flips the polarity at the pin. An overflow strobe marks each arrival at the bottom.

Top module: `pcpwm_timer`

## Requirements
- R1: `presc_sel_i` picks the tick divider N: 0→1, 1→8, 2→32, 3→64, 4→128, 5→256, 6→1024. Code 7 stops the timer: no ticks, the counter and the output hold. The divider is a free-running 10-bit counter from reset, so with N selected the counter steps on every N-th clock edge after reset release.
- R2: On successive ticks the counter runs 0,1,…,255,254,…,1,0,1,… with each endpoint visited once, so consecutive overflow strobes lie N×510 clocks apart.
- R3: `ovf_o` is high for exactly one clock, in the cycle in which the counter has just stepped down to 0.
- R4: With `invert_i`=0 and an active compare C strictly between 0 and 255, `pwm_o` is high while the count is below C and low otherwise. It drops on the up-count match and rises again on the down-count match.
- R5: An active compare of 0 keeps `pwm_o` low for the whole period when `invert_i`=0.
- R6: An active compare of 255 keeps `pwm_o` high for the whole period when `invert_i`=0, including the cycle at the top.
- R7: `invert_i`=1 gives the bitwise complement of the non-inverted output, including the constant levels of R5 and R6. It takes effect without waiting for a tick.
- R8: `cmp_i` is sampled only on the tick that brings the counter to 255. Changes at any other time have no effect on `pwm_o` until that point.
- R9: At the top the output takes the up-match level (low when not inverted) whenever the active compare is not 255. When the compare moves away from 255, the output therefore falls at the top with no match.
- R10: While reset is low: count 0 and rising, active compare 0, internal level low, so `pwm_o` equals `invert_i` and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| presc_sel_i | input | 3 | tick divider select, 7 = stopped |
| cmp_i | input | 8 | buffered compare value, taken at the top |
| invert_i | input | 1 | 1 = inverted output polarity |
| pwm_o | output | 1 | PWM waveform |
| ovf_o | output | 1 | one-clock strobe on reaching the bottom |

## Verification
The bench uses the default 8-bit width. With divide-by-1, complete 510-cycle sweeps are short, so every cycle of several periods is compared against a reference model. The bench covers the compare extremes, polarity flips, a compare write in mid-period and the forced edge at the top when the compare leaves 255. Divide-by-8 makes the overflow spacing measurable as 4080 clocks. Divide-by-1024 and the stop code exercise the clock-enable path without running whole slow periods.

// File: rtl/pcpwm_pkg.sv
`timescale 1ns/1ps
package pcpwm_pkg;
  localparam int PRE_W = 10;

  typedef enum logic [2:0] {
    PS_1, PS_8, PS_32, PS_64, PS_128, PS_256, PS_1024, PS_STOP
  } presc_e;

  function automatic logic [PRE_W-1:0] presc_mask(presc_e s);
    case (s)
      PS_8:    presc_mask = PRE_W'(7);
      PS_32:   presc_mask = PRE_W'(31);
      PS_64:   presc_mask = PRE_W'(63);
      PS_128:  presc_mask = PRE_W'(127);
      PS_256:  presc_mask = PRE_W'(255);
      PS_1024: presc_mask = PRE_W'(1023);
      default: presc_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
`timescale 1ns/1ps
module pcpwm_prescaler
  import pcpwm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  presc_e sel_i,
  output logic   tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             run;

  assign run    = (sel_i != PS_STOP);
  assign mask   = presc_mask(sel_i);
  assign tick_o = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else          pre_q <= '0;
  end

  // R1
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == PS_STOP) |=> (pre_q == '0));
endmodule

// File: rtl/pcpwm_counter.sv
`timescale 1ns/1ps
module pcpwm_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] cnt_nxt_o,
  output logic             top_load_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cnt_nxt;
  logic             up_q, up_nxt, ovf_q;

  always_comb begin
    cnt_nxt = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
    if (up_q && cnt_nxt == MAX)      up_nxt = 1'b0;
    else if (!up_q && cnt_nxt == '0) up_nxt = 1'b1;
    else                             up_nxt = up_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= tick_i && !up_q && (cnt_nxt == '0);
      if (tick_i) begin
        cnt_q <= cnt_nxt;
        up_q  <= up_nxt;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_nxt;
  assign top_load_o = tick_i && up_q && (cnt_nxt == MAX);
  assign ovf_o      = ovf_q;

  // R2
  bottom_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> up_q);
  // R2
  top_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX) |-> !up_q);
  // R3
  ovf_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));
endmodule

// File: rtl/pcpwm_compare.sv
`timescale 1ns/1ps
module pcpwm_compare #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] cnt_nxt_i,
  input  logic [WIDTH-1:0] cmp_i,
  output logic             level_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] ocr_q, ocr_nxt;
  logic             level_q, level_nxt;

  // below compare -> high; top compare pins high; at MAX the up-match level wins
  always_comb begin
    ocr_nxt   = load_i ? cmp_i : ocr_q;
    level_nxt = (cnt_nxt_i < ocr_nxt) || (ocr_nxt == MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q   <= '0;
      level_q <= 1'b0;
    end else if (tick_i) begin
      ocr_q   <= ocr_nxt;
      level_q <= level_nxt;
    end
  end

  assign level_o = level_q;

  // R5
  cmp_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocr_q == '0) |-> !level_q);
  // R6
  cmp_max_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocr_q == MAX) |-> level_q);
  // R9
  top_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == MAX) && (ocr_q != MAX)) |-> !level_q);
  // R8
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ocr_q));
endmodule

// File: rtl/pcpwm_timer.sv
`timescale 1ns/1ps
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       presc_sel_i,
  input  logic [WIDTH-1:0] cmp_i,
  input  logic             invert_i,
  output logic             pwm_o,
  output logic             ovf_o
);
  logic             tick;
  logic [WIDTH-1:0] cnt, cnt_nxt;
  logic             top_load, level;
  presc_e           sel;

  assign sel = presc_e'(presc_sel_i);

  pcpwm_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .tick_o (tick)
  );

  pcpwm_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .top_load_o (top_load),
    .ovf_o      (ovf_o)
  );

  pcpwm_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .load_i    (top_load),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .cmp_i     (cmp_i),
    .level_o   (level)
  );

  assign pwm_o = level ^ invert_i;

  // R1
  stop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == PS_STOP) |=> $stable(cnt));
  // R3
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

// File: tb/sim_pcpwm_timer.sv
`timescale 1ns/1ps
module sim_pcpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 255;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic [7:0] cmp_val = 8'd0;
  logic       invert = 1'b0;
  logic       pwm, ovf;

  pcpwm_timer #(.WIDTH(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .presc_sel_i(presc_sel),
    .cmp_i(cmp_val), .invert_i(invert), .pwm_o(pwm), .ovf_o(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic pwm; logic ovf; string req; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_bad = 0;
  string cur_req = "R10";
  int m_pre, m_cnt, m_ocr;
  bit m_up, m_lvl, m_ovf;
  int cyc = 0, prev_ovf = -1, last_gap = -1;

  function automatic int n_of(int s);
    case (s)
      0: return 1;    1: return 8;    2: return 32;  3: return 64;
      4: return 128;  5: return 256;  6: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic act, logic expv, string what);
    n_checks++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", req, what, act, expv, cyc);
    end
  endtask

  // driver: one clock edge of the reference model, expected result queued
  task automatic step();
    bit tick;
    int n;
    exp_t e;
    @(posedge clk);
    n = n_of(presc_sel);
    tick = (n != 0) && ((m_pre % n) == n - 1);
    m_pre = (n != 0) ? m_pre + 1 : 0;
    m_ovf = 1'b0;
    if (tick) begin
      if (m_up) begin
        m_cnt++;
        if (m_cnt == MAXV) begin m_up = 1'b0; m_ocr = cmp_val; end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin m_up = 1'b1; m_ovf = 1'b1; end
      end
      m_lvl = (m_cnt < m_ocr) || (m_ocr == MAXV);
    end
    e.pwm = m_lvl ^ invert;
    e.ovf = m_ovf;
    e.req = cur_req;
    exp_q.push_back(e);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drive(int sel, int cv, bit inv);
    @(negedge clk);
    presc_sel = 3'(sel);
    cmp_val   = 8'(cv);
    invert    = inv;
  endtask

  task automatic do_reset(int sel, int cv, bit inv);
    @(negedge clk);
    rst_ni = 1'b0;
    presc_sel = 3'(sel); cmp_val = 8'(cv); invert = inv;
    @(negedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", pwm, inv, "pwm in reset");
    check("R10", ovf, 1'b0, "ovf in reset");
    m_pre = 0; m_cnt = 0; m_up = 1'b1; m_ocr = 0; m_lvl = 1'b0; m_ovf = 1'b0;
    exp_q.delete();
    prev_ovf = -1; last_gap = -1;
    rst_ni = 1'b1;
  endtask

  // monitor
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    cyc++;
    if (rst_ni && ovf === 1'b1) begin
      if (prev_ovf >= 0) last_gap = cyc - prev_ovf;
      prev_ovf = cyc;
    end
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, pwm, e.pwm, "pwm");
      check(e.req, ovf, e.ovf, "ovf");
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    // R10 and R7 during reset
    do_reset(0, 100, 1'b1);
    do_reset(0, 100, 1'b0);

    // R4, R2, R3: mid-range compare, divide by 1
    cur_req = "R4";
    run(1100);
    n_checks++;
    if (last_gap != 510) begin
      n_bad++;
      $display("FAIL R2 overflow gap: actual=%0d expected=510", last_gap);
    end
    cur_req = "R3";
    run(520);

    // R5 compare zero, then R7 inverted
    do_reset(0, 0, 1'b0);
    cur_req = "R5";
    run(1100);
    drive(0, 0, 1'b1);
    cur_req = "R7";
    run(600);

    // R6 compare top, then R7 inverted
    do_reset(0, MAXV, 1'b0);
    cur_req = "R6";
    run(1100);
    drive(0, MAXV, 1'b1);
    cur_req = "R7";
    run(600);

    // R8: mid-period write takes effect only at the top
    do_reset(0, 100, 1'b0);
    cur_req = "R8";
    run(300);
    drive(0, 200, 1'b0);
    run(200);
    drive(0, 30, 1'b0);
    run(900);

    // R9: compare leaves 255, forced fall at the top
    do_reset(0, MAXV, 1'b0);
    cur_req = "R9";
    run(600);
    drive(0, 100, 1'b0);
    run(800);
    drive(0, 1, 1'b0);
    run(600);

    // R1: divide by 8, overflow spacing 4080
    do_reset(1, 60, 1'b0);
    cur_req = "R1";
    run(8300);
    n_checks++;
    if (last_gap != 4080) begin
      n_bad++;
      $display("FAIL R1 overflow gap N=8: actual=%0d expected=4080", last_gap);
    end
    // R1 stop code holds everything, then resume
    drive(7, 60, 1'b0);
    run(2000);
    drive(0, 60, 1'b0);
    run(700);
    // R1 divide by 1024
    do_reset(6, 2, 1'b0);
    run(4200);

    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule